// File: doc/BRIEF.md
# Conditional Control-Flow Execution Unit

This unit carries out the jump, call, return and restart instructions of an 8-bit processor with a 16-bit address space. A sequencer upstream hands it a decoded opcode byte together with the flags byte, the program counter, the stack pointer and HL. The incoming PC must already point at the byte after the opcode, which is where any 16-bit operand begins. The unit tests the condition that the opcode selects. It fetches the operand word or pops a word through a byte-wide synchronous memory port, and it pushes return addresses when the instruction needs it. It then returns the new PC, the new SP and the instruction's clock-state count in a one-cycle `done` pulse.

The memory port allows only one access at a time. Read data comes back on `mem_rdata` in the cycle after the request. Words are stored little-endian. A push writes the high byte at SP-1 and then the low byte at SP-2. A pop reads the low byte at SP and then the high byte at SP+1.

The sequencer is a single finite-state machine. `S_IDLE` takes `start` and latches the inputs, then goes to `S_DISPATCH`. `S_DISPATCH` classifies the opcode and evaluates the condition. From there it goes to `S_RD_LO` for a taken jump, a taken call or a taken return. It goes to `S_PUSH_HI` for a restart. Every other case goes to `S_FINISH`. The read sequence always runs `S_RD_LO` then `S_RD_HI` then `S_RD_END`. `S_RD_END` continues to `S_PUSH_HI` for a call and to `S_FINISH` otherwise. `S_PUSH_HI` goes to `S_PUSH_LO`, which goes to `S_FINISH`. `S_FINISH` raises `done` and returns to `S_IDLE`.

Top module: `flow_exec_unit`

## Requirements
- R1: Opcode bits 5:3 pick the condition: 0 Z clear, 1 Z set, 2 C clear, 3 C set, 4 P/V clear, 5 P/V set, 6 S clear, 7 S set. The flag bits are S = bit 7, Z = bit 6, P/V = bit 2 and C = bit 0. No other flag bit has any effect.
- R2: Conditional return (0xC0+8n) that is not taken leaves PC and SP unchanged and reports 5 states. When taken it pops PC, adds 2 to SP and reports 11 states. Unconditional return (0xC9) pops PC and reports 10 states.
- R3: Conditional jump (0xC2+8n) reports 10 states. When taken it loads PC with the operand word at PC. When not taken it sets PC to PC+2. Unconditional jump (0xC3) always loads the operand. SP is unchanged in every case.
- R4: Conditional call (0xC4+8n) that is taken, and unconditional call (0xCD), push PC+2, load PC with the operand, subtract 2 from SP and report 17 states. A conditional call that is not taken sets PC to PC+2, writes no memory and reports 10 states.
- R5: Restart (0xC7+8n) pushes the incoming PC, loads PC with n*8 and reports 11 states.
- R6: Jump through HL (0xE9) copies HL into PC, leaves SP unchanged and reports 4 states.
- R7: A push writes the high byte at SP-1 and then the low byte at SP-2. A pop reads the low byte at SP and then the high byte at SP+1.
- R8: All PC and SP arithmetic, and every memory address, wraps modulo 65536.
- R9: `done` is high for exactly one cycle per accepted instruction. `busy` is high from the cycle after `start` is accepted until `done`. A `start` that arrives while busy is ignored.
- R10: Any other opcode completes with PC and SP unchanged and a count of 0, and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted only while idle) |
| opcode | input | 8 | Decoded opcode byte |
| flags | input | 8 | Flags byte |
| pc_in | input | 16 | Address of the byte after the opcode |
| sp_in | input | 16 | Stack pointer |
| hl_in | input | 16 | HL register pair |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New PC, valid with done |
| sp_out | output | 16 | New SP, valid with done |
| states_out | output | 8 | Clock-state count, valid with done |

## Verification
The assertions rely on the memory answering every read in exactly the following cycle. They also rely on `start` being held for only one cycle, so that a new request is never confused with a completed one. The bench memory returns read data on the next edge from a 256-byte store indexed by the low address byte. Each scenario places its operand and stack bytes at addresses whose low bytes differ, so no access aliases another. The bench raises `start` for a single cycle. It pulses `start` a second time only in the scenario that deliberately tests a request arriving while busy.

// File: rtl/flow_pkg.sv
package flow_pkg;
    typedef enum logic [2:0] {
        K_NONE, K_RET, K_JP, K_CALL, K_RST, K_JPHL
    } kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_DISPATCH, S_RD_LO, S_RD_HI, S_RD_END,
        S_PUSH_HI, S_PUSH_LO, S_FINISH
    } state_t;

    localparam int T_RET_SKIP  = 5;
    localparam int T_RET_TAKEN = 11;
    localparam int T_RET_PLAIN = 10;
    localparam int T_JUMP      = 10;
    localparam int T_CALL_SKIP = 10;
    localparam int T_CALL_DO   = 17;
    localparam int T_RESTART   = 11;
    localparam int T_JUMP_HL   = 4;
endpackage

// File: rtl/flow_op_classify.sv
module flow_op_classify
    import flow_pkg::*;
(
    input  logic [7:0] op,
    output kind_t      kind,
    output logic       is_cond
);
    always_comb begin
        kind    = K_NONE;
        is_cond = 1'b0;
        if (op[7:6] == 2'b11) begin
            unique case (op[2:0])
                3'b000: begin kind = K_RET;  is_cond = 1'b1; end
                3'b010: begin kind = K_JP;   is_cond = 1'b1; end
                3'b100: begin kind = K_CALL; is_cond = 1'b1; end
                3'b111: kind = K_RST;
                default: begin
                    unique case (op[5:0])
                        6'h09:   kind = K_RET;
                        6'h03:   kind = K_JP;
                        6'h0D:   kind = K_CALL;
                        6'h29:   kind = K_JPHL;
                        default: kind = K_NONE;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/flow_cond_check.sv
module flow_cond_check #(
    parameter int SIGN_BIT   = 7,
    parameter int ZERO_BIT   = 6,
    parameter int PARITY_BIT = 2,
    parameter int CARRY_BIT  = 0
) (
    input  logic [2:0] sel,
    input  logic [7:0] flags,
    output logic       ok
);
    logic [2:0] pos;

    always_comb begin
        unique case (sel[2:1])
            2'd0: pos = 3'(ZERO_BIT);
            2'd1: pos = 3'(CARRY_BIT);
            2'd2: pos = 3'(PARITY_BIT);
            default: pos = 3'(SIGN_BIT);
        endcase
        // even selector tests for a clear flag, odd for a set flag (R1)
        ok = (flags[pos] == sel[0]);
    end
endmodule

// File: rtl/flow_exec_unit.sv
module flow_exec_unit
    import flow_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [7:0]            opcode,
    input  logic [7:0]            flags,
    input  logic [2*DATA_W-1:0]   pc_in,
    input  logic [2*DATA_W-1:0]   sp_in,
    input  logic [2*DATA_W-1:0]   hl_in,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  busy,
    output logic                  done,
    output logic [2*DATA_W-1:0]   pc_out,
    output logic [2*DATA_W-1:0]   sp_out,
    output logic [CNT_W-1:0]      states_out
);
    localparam int ADDR_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    state_t              state, state_nx;
    logic [7:0]          op_q, flags_q;
    logic [ADDR_W-1:0]   pc_q, sp_q, hl_q, ret_q, word_q;
    logic [CNT_W-1:0]    cyc_q;
    kind_t               kind;
    logic                is_cond, cond_ok, taken;
    logic [ADDR_W-1:0]   rd_base;

    flow_op_classify u_class (
        .op      (op_q),
        .kind    (kind),
        .is_cond (is_cond)
    );

    flow_cond_check u_cond (
        .sel   (op_q[5:3]),
        .flags (flags_q),
        .ok    (cond_ok)
    );

    assign taken = !is_cond || cond_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = S_DISPATCH;
            S_DISPATCH: begin
                unique case (kind)
                    K_JP, K_CALL, K_RET: state_nx = taken ? S_RD_LO : S_FINISH;
                    K_RST:               state_nx = S_PUSH_HI;
                    default:             state_nx = S_FINISH;
                endcase
            end
            S_RD_LO:    state_nx = S_RD_HI;
            S_RD_HI:    state_nx = S_RD_END;
            S_RD_END:   state_nx = (kind == K_CALL) ? S_PUSH_HI : S_FINISH;
            S_PUSH_HI:  state_nx = S_PUSH_LO;
            S_PUSH_LO:  state_nx = S_FINISH;
            S_FINISH:   state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_base   = (kind == K_RET) ? sp_q : pc_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (state)
            S_RD_LO:   begin mem_req = 1'b1; mem_addr = rd_base; end
            S_RD_HI:   begin mem_req = 1'b1; mem_addr = rd_base + ONE; end
            S_PUSH_HI: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = sp_q - ONE; mem_wdata = ret_q[ADDR_W-1:DATA_W];
            end
            S_PUSH_LO: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = sp_q - TWO; mem_wdata = ret_q[DATA_W-1:0];
            end
            S_FINISH:  done = 1'b1;
            default:   ;
        endcase
    end

    assign busy       = (state != S_IDLE);
    assign pc_out     = pc_q;
    assign sp_out     = sp_q;
    assign states_out = cyc_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0; flags_q <= '0; pc_q <= '0; sp_q <= '0;
            hl_q <= '0; ret_q <= '0; word_q <= '0; cyc_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    op_q <= opcode; flags_q <= flags; pc_q <= pc_in;
                    sp_q <= sp_in;  hl_q <= hl_in;    cyc_q <= '0;
                end
                S_DISPATCH: begin
                    unique case (kind)
                        K_JP: begin
                            cyc_q <= CNT_W'(T_JUMP);
                            if (!taken) pc_q <= pc_q + TWO;
                        end
                        K_CALL: begin
                            if (taken) begin
                                ret_q <= pc_q + TWO;
                                cyc_q <= CNT_W'(T_CALL_DO);
                            end else begin
                                pc_q  <= pc_q + TWO;
                                cyc_q <= CNT_W'(T_CALL_SKIP);
                            end
                        end
                        K_RET: begin
                            if (!is_cond)   cyc_q <= CNT_W'(T_RET_PLAIN);
                            else if (taken) cyc_q <= CNT_W'(T_RET_TAKEN);
                            else            cyc_q <= CNT_W'(T_RET_SKIP);
                        end
                        K_RST: begin
                            ret_q  <= pc_q;
                            word_q <= ADDR_W'({op_q[5:3], 3'b000});
                            cyc_q  <= CNT_W'(T_RESTART);
                        end
                        K_JPHL: begin
                            pc_q  <= hl_q;
                            cyc_q <= CNT_W'(T_JUMP_HL);
                        end
                        default: cyc_q <= '0;
                    endcase
                end
                S_RD_HI: word_q[DATA_W-1:0] <= mem_rdata;
                S_RD_END: begin
                    word_q[ADDR_W-1:DATA_W] <= mem_rdata;
                    if (kind == K_RET) begin
                        pc_q <= {mem_rdata, word_q[DATA_W-1:0]};
                        sp_q <= sp_q + TWO;
                    end else if (kind == K_JP) begin
                        pc_q <= {mem_rdata, word_q[DATA_W-1:0]};
                    end
                end
                S_PUSH_LO: begin
                    sp_q <= sp_q - TWO;
                    pc_q <= word_q;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_q));

    assert_push_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH_LO) |-> ($past(mem_we) && mem_req && mem_we
                                  && mem_addr == $past(mem_addr) - ONE));

    assert_pop_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_HI) |-> ($past(mem_req) && !$past(mem_we)
                                && mem_addr == $past(mem_addr) + ONE));

    assert_rst_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind == K_RST) |-> (pc_out[2:0] == 3'b000
                                     && pc_out[ADDR_W-1:6] == '0));

    assert_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind == K_NONE) |-> !mem_req);

    assert_jphl_keeps_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind == K_JPHL) |-> (sp_out == hl_q - hl_q + sp_q && states_out == CNT_W'(T_JUMP_HL)));
endmodule

// File: tb/flow_exec_unit_test.sv
module flow_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, flags = '0;
    logic [15:0] pc_in = '0, sp_in = '0, hl_in = '0;
    logic        mem_req, mem_we, busy, done;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, mem_rdata, states_out;

    int checks = 0, errors = 0;
    int wr_count = 0, rd_count = 0;
    logic [7:0]  mem [256];
    logic [15:0] got_pc, got_sp;
    logic [7:0]  got_cyc;
    logic        timed_out = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flow_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .flags(flags), .pc_in(pc_in), .sp_in(sp_in), .hl_in(hl_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .pc_out(pc_out), .sp_out(sp_out),
        .states_out(states_out)
    );

    // synchronous byte memory, read data next cycle
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr[7:0]] = mem_wdata;
            wr_count = wr_count + 1;
        end else if (mem_req) begin
            mem_rdata <= mem[mem_addr[7:0]];
            rd_count = rd_count + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // condition truth per R1 table: S=7 Z=6 P/V=2 C=0
    function automatic logic cond_true(input logic [2:0] n, input logic [7:0] f);
        logic b;
        case (n[2:1])
            2'd0: b = f[6];
            2'd1: b = f[0];
            2'd2: b = f[2];
            default: b = f[7];
        endcase
        return n[0] ? b : ~b;
    endfunction

    task automatic run_op(input logic [7:0] op, input logic [7:0] f,
                          input logic [15:0] pc, input logic [15:0] sp,
                          input logic [15:0] hl);
        @(negedge clk);
        opcode = op; flags = f; pc_in = pc; sp_in = sp; hl_in = hl;
        wr_count = 0; rd_count = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (done) break;
            @(negedge clk);
        end
        if (!done) begin
            timed_out = 1'b1;
            checks++; errors++;
            $display("FAIL R9 done never seen for opcode %h: actual 0 expected 1", op);
        end
        got_pc = pc_out; got_sp = sp_out; got_cyc = states_out;
    endtask

    task automatic t_reset();
        check("R9", "busy after reset", {15'b0, busy}, 16'd0);
        check("R9", "done after reset", {15'b0, done}, 16'd0);
        check("R10", "no access after reset", {15'b0, mem_req}, 16'd0);
    endtask

    task automatic t_cond_jump();
        for (int n = 0; n < 8; n++) begin
            for (int w = 0; w < 2; w++) begin
                logic [7:0] f;
                logic       t;
                f = (w == 0) ? 8'h00 : 8'hFF;
                f = f ^ ((n % 2 == 1) ? 8'h00 : 8'h00);
                t = cond_true(3'(n), f);
                mem[8'h40] = 8'h34; mem[8'h41] = 8'h12;
                run_op(8'hC2 + 8'(8 * n), f, 16'h0440, 16'h8080, 16'h0);
                check("R3", "jp cc pc", got_pc, t ? 16'h1234 : 16'h0442);
                check("R3", "jp cc states", {8'h0, got_cyc}, 16'd10);
                check("R1", "jp cc sp kept", got_sp, 16'h8080);
            end
        end
        // other flag bits do not matter: Z set alone vs Z set with 0x3A noise
        mem[8'h40] = 8'hCD; mem[8'h41] = 8'hAB;
        run_op(8'hCA, 8'h7A, 16'h0440, 16'h8080, 16'h0);
        check("R1", "jp z with noise bits", got_pc, 16'hABCD);
        run_op(8'hC2, 8'h3A ^ 8'h40 ^ 8'h40 | 8'h40, 16'h0440, 16'h8080, 16'h0);
        check("R1", "jp nz with Z set", got_pc, 16'h0442);
        run_op(8'hC3, 8'h00, 16'h0440, 16'h8080, 16'h0);
        check("R3", "jp nn pc", got_pc, 16'hABCD);
        check("R3", "jp nn states", {8'h0, got_cyc}, 16'd10);
    endtask

    task automatic t_ret();
        mem[8'h80] = 8'h78; mem[8'h81] = 8'h56;
        run_op(8'hD8, 8'h00, 16'h0300, 16'h1280, 16'h0);     // ret c, C clear
        check("R2", "ret c skip pc", got_pc, 16'h0300);
        check("R2", "ret c skip sp", got_sp, 16'h1280);
        check("R2", "ret c skip states", {8'h0, got_cyc}, 16'd5);
        check("R2", "ret skip no read", 16'(rd_count), 16'd0);
        run_op(8'hD8, 8'h01, 16'h0300, 16'h1280, 16'h0);
        check("R2", "ret c taken pc", got_pc, 16'h5678);
        check("R2", "ret c taken sp", got_sp, 16'h1282);
        check("R2", "ret c taken states", {8'h0, got_cyc}, 16'd11);
        run_op(8'hC9, 8'h00, 16'h0300, 16'h1280, 16'h0);
        check("R2", "ret pc", got_pc, 16'h5678);
        check("R2", "ret states", {8'h0, got_cyc}, 16'd10);
        check("R7", "pop reads two bytes", 16'(rd_count), 16'd2);
    endtask

    task automatic t_call();
        mem[8'h20] = 8'hEF; mem[8'h21] = 8'hBE;
        mem[8'h8E] = 8'h00; mem[8'h8F] = 8'h00;
        run_op(8'hF4, 8'h00, 16'h0220, 16'h2290, 16'h0);     // call p, S clear
        check("R4", "call p pc", got_pc, 16'hBEEF);
        check("R4", "call p sp", got_sp, 16'h228E);
        check("R4", "call p states", {8'h0, got_cyc}, 16'd17);
        check("R7", "push high at sp-1", {8'h0, mem[8'h8F]}, 16'h0002);
        check("R7", "push low at sp-2", {8'h0, mem[8'h8E]}, 16'h0022);
        run_op(8'hF4, 8'h80, 16'h0220, 16'h2290, 16'h0);
        check("R4", "call p skip pc", got_pc, 16'h0222);
        check("R4", "call p skip states", {8'h0, got_cyc}, 16'd10);
        check("R4", "call skip no write", 16'(wr_count), 16'd0);
        run_op(8'hCD, 8'h00, 16'h0220, 16'h2290, 16'h0);
        check("R4", "call nn states", {8'h0, got_cyc}, 16'd17);
        check("R4", "call nn pc", got_pc, 16'hBEEF);
    endtask

    task automatic t_rst();
        for (int n = 0; n < 8; n++) begin
            run_op(8'hC7 + 8'(8 * n), 8'h00, 16'h9A5B, 16'h40A0, 16'h0);
            check("R5", "rst vector", got_pc, 16'(8 * n));
            check("R5", "rst states", {8'h0, got_cyc}, 16'd11);
            check("R5", "rst sp", got_sp, 16'h409E);
            check("R5", "rst pushed pc", {mem[8'h9F], mem[8'h9E]}, 16'h9A5B);
        end
    endtask

    task automatic t_jphl();
        run_op(8'hE9, 8'h00, 16'h0100, 16'h3333, 16'hC0DE);
        check("R6", "jp hl pc", got_pc, 16'hC0DE);
        check("R6", "jp hl sp", got_sp, 16'h3333);
        check("R6", "jp hl states", {8'h0, got_cyc}, 16'd4);
    endtask

    task automatic t_wrap();
        mem[8'h50] = 8'h11; mem[8'h51] = 8'h22;
        run_op(8'hCD, 8'h00, 16'h0150, 16'h0001, 16'h0);
        check("R8", "push wrap sp", got_sp, 16'hFFFF);
        check("R8", "push wrap high at 0000", {8'h0, mem[8'h00]}, 16'h0001);
        check("R8", "push wrap low at FFFF", {8'h0, mem[8'hFF]}, 16'h0052);
        run_op(8'hC9, 8'h00, 16'h0150, 16'hFFFF, 16'h0);
        check("R8", "pop wrap pc", got_pc, 16'h0152);
        check("R8", "pop wrap sp", got_sp, 16'h0001);
        run_op(8'hC2, 8'h40, 16'hFFFF, 16'h1000, 16'h0);
        check("R8", "pc skip wrap", got_pc, 16'h0001);
    endtask

    task automatic t_illegal();
        run_op(8'h00, 8'hFF, 16'h0777, 16'h5555, 16'h1);
        check("R10", "nop-like pc", got_pc, 16'h0777);
        check("R10", "nop-like sp", got_sp, 16'h5555);
        check("R10", "nop-like states", {8'h0, got_cyc}, 16'd0);
        run_op(8'hC1, 8'h00, 16'h0777, 16'h5555, 16'h1);
        check("R10", "C1 no access", 16'(rd_count + wr_count), 16'd0);
        check("R10", "C1 states", {8'h0, got_cyc}, 16'd0);
    endtask

    task automatic t_busy();
        @(negedge clk);
        opcode = 8'hE9; flags = 8'h0; pc_in = 16'h0; sp_in = 16'h7000; hl_in = 16'h4321;
        start = 1'b1;
        @(negedge clk);
        opcode = 8'hC3; hl_in = 16'h9999;   // second start while busy
        check("R9", "busy after start", {15'b0, busy}, 16'd1);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (done) break;
            @(negedge clk);
        end
        check("R9", "first request wins", pc_out, 16'h4321);
        @(negedge clk);
        check("R9", "done one cycle", {15'b0, done}, 16'd0);
        check("R9", "idle after done", {15'b0, busy}, 16'd0);
    endtask

    initial begin : watchdog
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cond_jump();
        t_ret();
        t_call();
        t_rst();
        t_jphl();
        t_wrap();
        t_illegal();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule